// File: doc/BRIEF.md
# Bridge Control Register File

This block is a bank of twenty-eight 32-bit control words behind a plain word-wide register port. The words sit at byte addresses `0x100` through `0x16C` of the register space, one word every four bytes. The bank holds the following groups:

- bridge configuration words;
- a GPIO value and a GPIO enable word;
- interrupt trigger, routing and polarity words;
- four mailbox words;
- cache, timing, CPU and memory-size words.

The interrupt-enable mask cannot be written directly. Software changes it through two side doors: a word that sets mask bits where it is written with ones, and a word that clears them.

The block also watches one bit of the general bridge configuration word. When software moves that bit from 0 to 1, the block asks the rest of the chip for a system reset. Every word comes out of reset at a fixed value.

The port takes one access per clock cycle and has no back-pressure. There is no valid/ready pair because no access can be refused. A write is committed on the clock edge at which `reg_wr_en` is high. Read data is a combinational function of `reg_addr`, so it is valid in the same cycle as the address.

Top module: `bridge_ctrl_regs`

## Requirements
- R1: Word i (0 to 27) sits at byte address `0x100 + 4*i`. A write to it is visible on `reg_rd_data` from the cycle after the write edge, whenever `reg_addr` selects it.
- R2: After reset the words read as follows; every other word reads 0:
  - word 0 = `0xC40`
  - word 1 = `0x1384`
  - word 2 = `0x2BFF8010`
  - word 3 = `0x255E0091`
  - word 4 = `0x6140`
  - words 7 and 8 = `0x1FF`
  - word 26 = `0x8`
  - word 27 = `0x10000000`
- R3: A write to word 12 (`0x130`) stores the data in word 12 and ORs it into the enable mask, word 14.
- R4: A write to word 13 (`0x134`) stores the data in word 13 and clears in word 14 every bit that is 1 in the data.
- R5: Direct writes to word 14 (`0x138`) and word 15 (`0x13C`, interrupt status) have no effect. Word 15 always reads 0.
- R6: Every other word in the bank stores the full 32-bit write data. A write changes no word other than the one it addresses, apart from the word-14 side effects in R3 and R4.
- R7: `sys_rst_req` is high in the cycle after a write to word 1 (`0x104`) that takes bit 2 of that word from 0 to 1. It stays low after writes that leave bit 2 at 1, after writes that clear it, and after writes to any other address.
- R8: `sys_rst_req` is a one-cycle pulse.
- R9: Addresses below `0x100`, at or above `0x170`, or with either of the two low address bits set are outside the bank. Writes to them are ignored and reads from them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | 12 | Byte address of the access |
| reg_wr_en | input | 1 | Commit a write at this clock edge |
| reg_wr_data | input | 32 | Write data |
| reg_rd_data | output | 32 | Read data for `reg_addr`, combinational |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
The assertions assume at most one write per cycle and assume that `reg_wr_en` is low while `rst` is high. Under those assumptions, the cycle before each enable-mask or reset-request check contains only the write whose effect is being checked. The stimulus drives inputs only on falling edges and holds `reg_wr_en` low for the whole reset period. Random addresses are mixed deliberately across in-bank aligned words, misaligned offsets and out-of-bank addresses. Bit 2 of word 1 is toggled on purpose so that the reset-request edge is exercised, and not only reached by chance.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
  localparam int NUM_WORDS = 28;
  localparam int DATA_W    = 32;

  localparam int W_PWRON   = 0;
  localparam int W_GENCFG  = 1;
  localparam int W_IODEV   = 2;
  localparam int W_SDRAM   = 3;
  localparam int W_PMAP    = 4;
  localparam int W_GPIO_D  = 7;
  localparam int W_GPIO_E  = 8;
  localparam int W_EN_SET  = 12;
  localparam int W_EN_CLR  = 13;
  localparam int W_EN_MASK = 14;
  localparam int W_IRQ_ST  = 15;
  localparam int W_DQ      = 26;
  localparam int W_MEMSZ   = 27;

  // Bit of the general configuration word whose rising write asks for reset
  localparam int RST_BIT = 2;

  function automatic logic [DATA_W-1:0] init_value(input int idx);
    case (idx)
      W_PWRON:  return 32'h0000_0C40;
      W_GENCFG: return 32'h0000_1384;
      W_IODEV:  return 32'h2BFF_8010;
      W_SDRAM:  return 32'h255E_0091;
      W_PMAP:   return 32'h0000_6140;
      W_GPIO_D: return 32'h0000_01FF;
      W_GPIO_E: return 32'h0000_01FF;
      W_DQ:     return 32'h0000_0008;
      W_MEMSZ:  return 32'h1000_0000;
      default:  return '0;
    endcase
  endfunction
endpackage

// File: rtl/bcr_decode.sv
module bcr_decode #(
  parameter int ADDR_W    = 12,
  parameter int BASE      = 'h100,
  parameter int NUM_WORDS = 28,
  localparam int IDX_W    = $clog2(NUM_WORDS)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  logic [ADDR_W-1:0] offset;

  always_comb begin
    offset = addr - ADDR_W'(BASE);
    idx    = offset[IDX_W+1:2];
    hit    = (addr >= ADDR_W'(BASE))
          && (offset[1:0] == 2'b00)
          && (offset[ADDR_W-1:IDX_W+2] == '0)
          && (int'(idx) < NUM_WORDS);
  end
endmodule

// File: rtl/bcr_word.sv
module bcr_word #(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] INIT = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= INIT;
    else if (we) q <= d;
  end

  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(q)); // R6
  AST_WORD_LOAD: assert property (@(posedge clk) disable iff (rst)
    we |=> (q == $past(d))); // R6
endmodule

// File: rtl/bcr_irq_mask.sv
module bcr_irq_mask #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] mask
);
  always_ff @(posedge clk) begin
    if (rst)         mask <= '0;
    else if (set_we) mask <= mask | d;
    else if (clr_we) mask <= mask & ~d;
  end

  AST_MASK_SET: assert property (@(posedge clk) disable iff (rst)
    set_we |=> ((mask & $past(d)) == $past(d))); // R3
  AST_MASK_CLR: assert property (@(posedge clk) disable iff (rst)
    (clr_we && !set_we) |=> ((mask & $past(d)) == '0)); // R4
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!set_we && !clr_we) |=> $stable(mask)); // R5
  AST_MASK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({set_we, clr_we})); // R6
endmodule

// File: rtl/bcr_rst_req.sv
module bcr_rst_req (
  input  logic clk,
  input  logic rst,
  input  logic gen_we,
  input  logic old_bit,
  input  logic new_bit,
  output logic req
);
  always_ff @(posedge clk) begin
    if (rst) req <= 1'b0;
    else     req <= gen_we && !old_bit && new_bit;
  end

  AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    req |-> $past(gen_we)); // R7
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    req |=> !req); // R8
endmodule

// File: rtl/bridge_ctrl_regs.sv
module bridge_ctrl_regs
  import bcr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BASE   = 'h100,
  localparam int IDX_W = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr_en,
  input  logic [DATA_W-1:0] reg_wr_data,
  output logic [DATA_W-1:0] reg_rd_data,
  output logic              sys_rst_req
);
  logic             hit;
  logic [IDX_W-1:0] idx;
  logic [NUM_WORDS-1:0] wsel;
  logic [DATA_W-1:0] words [NUM_WORDS];

  bcr_decode #(.ADDR_W(ADDR_W), .BASE(BASE), .NUM_WORDS(NUM_WORDS)) u_dec (
    .addr(reg_addr), .hit(hit), .idx(idx)
  );

  always_comb begin
    wsel = '0;
    if (reg_wr_en && hit) wsel[idx] = 1'b1;
  end

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    if (i == W_EN_MASK) begin : g_mask
      bcr_irq_mask #(.DATA_W(DATA_W)) u_mask (
        .clk(clk), .rst(rst),
        .set_we(wsel[W_EN_SET]), .clr_we(wsel[W_EN_CLR]),
        .d(reg_wr_data), .mask(words[i])
      );
    end else if (i == W_IRQ_ST) begin : g_stat
      assign words[i] = '0;
    end else begin : g_plain
      bcr_word #(.DATA_W(DATA_W), .INIT(init_value(i))) u_word (
        .clk(clk), .rst(rst), .we(wsel[i]),
        .d(reg_wr_data), .q(words[i])
      );
    end
  end

  bcr_rst_req u_rreq (
    .clk(clk), .rst(rst),
    .gen_we(wsel[W_GENCFG]),
    .old_bit(words[W_GENCFG][RST_BIT]),
    .new_bit(reg_wr_data[RST_BIT]),
    .req(sys_rst_req)
  );

  assign reg_rd_data = hit ? words[idx] : '0;

  AST_STATUS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (hit && int'(idx) == W_IRQ_ST) |-> (reg_rd_data == '0)); // R5
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !hit |-> (reg_rd_data == '0)); // R9
  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wsel)); // R1
endmodule

// File: tb/bridge_ctrl_regs_tb.sv
module bridge_ctrl_regs_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] reg_addr = '0;
  logic        reg_wr_en = 1'b0;
  logic [31:0] reg_wr_data = '0;
  logic [31:0] reg_rd_data;
  logic        sys_rst_req;

  int checks = 0;
  int errors = 0;
  logic [31:0] mdl [28];
  logic exp_req;

  always #4 clk = ~clk;

  bridge_ctrl_regs u_dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
    .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data),
    .sys_rst_req(sys_rst_req)
  );

  function automatic logic [31:0] rst_val(input int i);
    case (i)
      0: return 32'hC40;        1: return 32'h1384;
      2: return 32'h2BFF8010;   3: return 32'h255E0091;
      4: return 32'h6140;       7: return 32'h1FF;
      8: return 32'h1FF;        26: return 32'h8;
      27: return 32'h10000000;  default: return 32'h0;
    endcase
  endfunction

  function automatic bit in_bank(input logic [11:0] a);
    return (a >= 12'h100) && (a < 12'h170) && (a[1:0] == 2'b00);
  endfunction

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    if (!in_bank(a)) return 32'h0;
    return mdl[(a - 12'h100) >> 2];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic model_write(input logic [11:0] a, input logic [31:0] d);
    int i;
    exp_req = 1'b0;
    if (!in_bank(a)) return;
    i = (a - 12'h100) >> 2;
    if (i == 1) exp_req = !mdl[1][2] && d[2];
    if (i == 12) begin mdl[12] = d; mdl[14] = mdl[14] | d; end
    else if (i == 13) begin mdl[13] = d; mdl[14] = mdl[14] & ~d; end
    else if (i != 14 && i != 15) mdl[i] = d;
  endtask

  task automatic rd_check(input logic [11:0] a, input string req);
    @(negedge clk);
    reg_wr_en = 1'b0;
    reg_addr = a;
    #1 check(req, reg_rd_data, exp_read(a));
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string req);
    @(negedge clk);
    reg_addr = a; reg_wr_data = d; reg_wr_en = 1'b1;
    model_write(a, d);
    @(negedge clk);
    reg_wr_en = 1'b0;
    check({req, " R7 req"}, {31'b0, sys_rst_req}, {31'b0, exp_req});
    @(negedge clk);
    check("R8 pulse low", {31'b0, sys_rst_req}, 32'h0);
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < 28; i++) rd_check(12'h100 + 12'(4 * i), req);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [11:0] a;
    logic [31:0] d;
    int r;
    void'($urandom(32'd1234));
    for (int i = 0; i < 28; i++) mdl[i] = rst_val(i);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R8 reset low", {31'b0, sys_rst_req}, 32'h0);
    sweep("R2 reset values");

    // directed: enable mask set / clear, read-only words
    wr(12'h130, 32'hF0F0_00FF, "R3");  rd_check(12'h138, "R3 mask");
    rd_check(12'h130, "R3 stored");
    wr(12'h134, 32'h3000_000F, "R4");  rd_check(12'h138, "R4 mask");
    rd_check(12'h134, "R4 stored");
    wr(12'h138, 32'hFFFF_FFFF, "R5");  rd_check(12'h138, "R5 mask ignore");
    wr(12'h13C, 32'hFFFF_FFFF, "R5");  rd_check(12'h13C, "R5 status zero");
    // directed: reset request edge
    wr(12'h104, 32'h0000_1384, "R7 1to1");
    wr(12'h104, 32'h0000_1380, "R7 1to0");
    wr(12'h104, 32'h0000_0004, "R7 0to1");
    rd_check(12'h104, "R6 gencfg");
    // directed: out of bank and misaligned
    wr(12'h0FC, 32'hDEAD_BEEF, "R9");  rd_check(12'h0FC, "R9 below");
    wr(12'h170, 32'hDEAD_BEEF, "R9");  rd_check(12'h170, "R9 above");
    wr(12'h16E, 32'hDEAD_BEEF, "R9");  rd_check(12'h16C, "R9 misaligned");
    rd_check(12'h16E, "R9 misaligned read");
    wr(12'h16C, 32'hA5A5_5A5A, "R1");  rd_check(12'h16C, "R1 last word");
    sweep("R6 no side effects");

    // constrained random
    for (int n = 0; n < 400; n++) begin
      r = $urandom_range(0, 99);
      if (r < 70)      a = 12'h100 + 12'($urandom_range(0, 27) * 4);
      else if (r < 80) a = 12'h100 + 12'($urandom_range(0, 111));
      else if (r < 90) a = 12'($urandom_range(0, 255));
      else             a = 12'h170 + 12'($urandom_range(0, 143));
      d = $urandom();
      if (a == 12'h104 && $urandom_range(0, 1) == 1) d[2] = ~mdl[1][2];
      wr(a, d, "R6 random");
      rd_check(a, "R1 random readback");
      rd_check(12'h138, "R3 R4 random mask");
    end
    sweep("R6 final");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule